// File: doc/BRIEF.md
# Inter-processor message queue proxy

This block is a single hardware message queue that two processors share through a small window of 32-bit registers on a simple register bus. The producer assembles one 64-byte message by writing sixteen data registers. Its write to the highest data register commits the whole message to the queue.

The consumer reads the same sixteen registers to fetch the oldest pending message. Its read of the highest data register retires that message and exposes the next one.

A state register reports how many messages are waiting and whether a commit was ever lost to a full queue. A receive interrupt is held high while anything is pending, so a consumer can either poll the state register or wait on the interrupt.

Bus accesses take effect at the clock edge that samples them. Read data appears on `bus_rdata` after that edge and holds until the next read.

Top module: `mq_proxy`

## Requirements
- R1: After reset the pending count is 0, the overflow flag is 0, `rx_irq` is low and `bus_rdata` is 0.
- R2: A write to register index 31 commits the staged message, with the written value as its last word, and raises the pending count by one.
- R3: Messages leave in the order they were committed. A read of index 16+k returns word k of the oldest pending message, and a write to index 16+k stages word k.
- R4: A data word at indices 16..30 that was not written since the previous commit is stored as zero.
- R5: A read of index 31 while the count is nonzero returns the last word of the oldest message and then removes that message, lowering the count by one.
- R6: A read of index 0 (state register) returns the pending count in bits [23:12], the overflow flag in bit 0 and zero in every other bit.
- R7: `rx_irq` is high exactly while the pending count is nonzero. It falls in the cycle after the last pending message is removed.
- R8: While the queue is empty, reads of indices 16..31 return zero, and a read of index 31 leaves the count unchanged.
- R9: The queue holds 128 messages. A commit while 128 are pending is dropped and sets the overflow flag, which then stays set until reset.
- R10: Writes to indices outside 16..31, including the state register, change nothing. Reads of indices other than 0 and 16..31 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register index (word address) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid after the sampling edge |
| rx_irq | output | 1 | High while messages are pending |

## Verification
A wrong read pointer or a corrupted memory entry shows up at the very next data-window read, as a word that differs from the oldest committed message. A wrong count is visible one cycle later on `rx_irq` and on the next state register read. A staging mask that is not cleared on commit leaks words from an earlier message into a later one, so a partial message is committed right after a full one to expose it. Filling the queue past 128 and draining it completely checks the wrap of both pointers, the dropped commit and the stickiness of the overflow flag.

// File: rtl/mq_pkg.sv
package mq_pkg;

    // Classification of one bus access against the proxy window
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_STATE_RD,
        ACC_STAGE_WR,
        ACC_COMMIT,
        ACC_WORD_RD,
        ACC_POP_RD,
        ACC_OTHER
    } acc_e;

endpackage

// File: rtl/mq_stage.sv
module mq_stage #(
    parameter int WORDS = 16,
    parameter int DW    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(WORDS)-1:0]    wr_idx,
    input  logic [DW-1:0]               wr_data,
    input  logic                        commit,
    input  logic [DW-1:0]               last_data,
    output logic [WORDS-1:0][DW-1:0]    msg
);
    localparam int SW = WORDS - 1;

    typedef struct packed {
        logic [SW-1:0][DW-1:0] data;
        logic [SW-1:0]         mask;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.mask = '0;
        end else if (wr_en) begin
            for (int i = 0; i < SW; i++) begin
                if (wr_idx == ($clog2(WORDS))'(i)) begin
                    st_d.data[i] = wr_data;
                    st_d.mask[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Words not written since the last commit go out as zero
    for (genvar g = 0; g < SW; g++) begin : g_word
        assign msg[g] = st_q.mask[g] ? st_q.data[g] : '0;
    end
    assign msg[WORDS-1] = last_data;

    // R4: every commit empties the staging mask
    a_r4_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st_q.mask == '0));

endmodule

// File: rtl/mq_store.sv
module mq_store #(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [WORDS-1:0][DW-1:0]      push_msg,
    input  logic                          pop,
    input  logic [$clog2(WORDS)-1:0]      rd_idx,
    output logic [DW-1:0]                 head_word,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          ovf
);
    localparam int PW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0]    wr_ptr;
        logic [PW-1:0]    rd_ptr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [WORDS-1:0][DW-1:0] mem [DEPTH];
    logic full, empty, do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        full    = (c_q.cnt == CNT_W'(DEPTH));
        empty   = (c_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        c_d     = c_q;
        if (push && full) c_d.ovf = 1'b1;
        if (do_push) c_d.wr_ptr = nxt(c_q.wr_ptr);
        if (do_pop)  c_d.rd_ptr = nxt(c_q.rd_ptr);
        if (do_push && !do_pop) c_d.cnt = c_q.cnt + CNT_W'(1);
        if (do_pop && !do_push) c_d.cnt = c_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[c_q.wr_ptr] <= push_msg;
    end

    assign head_word = mem[c_q.rd_ptr][rd_idx];
    assign count     = c_q.cnt;
    assign ovf       = c_q.ovf;

    a_r2_commit_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count < CNT_W'(DEPTH)) |=> (count == $past(count) + CNT_W'(1)));
    a_r5_pop_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count != '0) |=> (count == $past(count) - CNT_W'(1)));
    a_r8_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0));
    a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == CNT_W'(DEPTH)) |=> (count == CNT_W'(DEPTH) && ovf));
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

endmodule

// File: rtl/mq_proxy.sv
module mq_proxy #(
    parameter int DW        = 32,
    parameter int AW        = 5,
    parameter int WORDS     = 16,
    parameter int DEPTH     = 128,
    parameter int FIRST_IDX = 16,
    parameter int STATE_IDX = 0,
    parameter int CNT_LSB   = 12,
    parameter int CNT_FLD_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rx_irq
);
    import mq_pkg::*;

    localparam int LAST_IDX = FIRST_IDX + WORDS - 1;
    localparam int IDX_W    = $clog2(WORDS);
    localparam int CNT_W    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rsp_t;

    rsp_t r_d, r_q;
    acc_e acc;
    logic in_win;
    logic [IDX_W-1:0] idx;
    logic [WORDS-1:0][DW-1:0] msg;
    logic [DW-1:0] head_word, state_word;
    logic [CNT_W-1:0] count;
    logic ovf;

    // Access decode
    always_comb begin
        in_win = (bus_addr >= AW'(FIRST_IDX)) && (bus_addr <= AW'(LAST_IDX));
        idx    = IDX_W'(bus_addr - AW'(FIRST_IDX));
        if (!bus_valid)                                  acc = ACC_IDLE;
        else if (bus_write && in_win &&
                 bus_addr == AW'(LAST_IDX))              acc = ACC_COMMIT;
        else if (bus_write && in_win)                    acc = ACC_STAGE_WR;
        else if (!bus_write && in_win &&
                 bus_addr == AW'(LAST_IDX))              acc = ACC_POP_RD;
        else if (!bus_write && in_win)                   acc = ACC_WORD_RD;
        else if (!bus_write && bus_addr == AW'(STATE_IDX)) acc = ACC_STATE_RD;
        else                                             acc = ACC_OTHER;
    end

    mq_stage #(.WORDS(WORDS), .DW(DW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc == ACC_STAGE_WR),
        .wr_idx    (idx),
        .wr_data   (bus_wdata),
        .commit    (acc == ACC_COMMIT),
        .last_data (bus_wdata),
        .msg       (msg)
    );

    mq_store #(.WORDS(WORDS), .DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (acc == ACC_COMMIT),
        .push_msg  (msg),
        .pop       (acc == ACC_POP_RD),
        .rd_idx    (idx),
        .head_word (head_word),
        .count     (count),
        .ovf       (ovf)
    );

    // State register image: count field and overflow flag
    always_comb begin
        state_word = '0;
        state_word[CNT_LSB +: CNT_FLD_W] = CNT_FLD_W'(count);
        state_word[0] = ovf;
    end

    always_comb begin
        r_d = r_q;
        case (acc)
            ACC_STATE_RD:            r_d.rdata = state_word;
            ACC_WORD_RD, ACC_POP_RD: r_d.rdata = (count != '0) ? head_word : '0;
            ACC_OTHER:               if (!bus_write) r_d.rdata = '0;
            default:                 r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign rx_irq    = (count != '0);

    // R7: the interrupt only falls right after a retiring read
    a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_irq) |-> $past(acc == ACC_POP_RD));
    // R10: writes outside the window leave read data and count alone
    a_r10_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_OTHER && bus_write) |=> ($stable(bus_rdata) && $stable(count)));

endmodule

// File: tb/mq_proxy_test.sv
module mq_proxy_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_irq;

    always #4 clk = ~clk;

    mq_proxy uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_irq(rx_irq)
    );

    // Behavioural reference
    logic [15:0][31:0] mq[$];
    logic [31:0] stg[16];
    bit          wrm[16];
    bit          m_ovf;
    logic [31:0] exp_rd;
    int          vectors = 0;
    int          fails = 0;
    string       cur_req = "R1";

    task automatic model(input bit v, input bit w, input int a, input logic [31:0] d);
        logic [15:0][31:0] m;
        if (v && w) begin
            if (a >= 16 && a <= 30) begin
                stg[a-16] = d; wrm[a-16] = 1'b1;
            end else if (a == 31) begin
                for (int i = 0; i < 15; i++) m[i] = wrm[i] ? stg[i] : 32'h0;
                m[15] = d;
                if (mq.size() < 128) mq.push_back(m); else m_ovf = 1'b1;
                for (int i = 0; i < 16; i++) wrm[i] = 1'b0;
            end
        end else if (v) begin
            if (a == 0) exp_rd = {8'h0, 12'(mq.size()), 11'h0, m_ovf};
            else if (a >= 16 && a <= 31) begin
                exp_rd = (mq.size() != 0) ? mq[0][a-16] : 32'h0;
                if (a == 31 && mq.size() != 0) void'(mq.pop_front());
            end else exp_rd = 32'h0;
        end
    endtask

    task automatic compare();
        vectors++;
        if (bus_rdata !== exp_rd) begin
            fails++;
            $display("FAIL %s: bus_rdata actual %h expected %h", cur_req, bus_rdata, exp_rd);
        end
        vectors++;
        if (rx_irq !== (mq.size() != 0)) begin
            fails++;
            $display("FAIL R7: rx_irq actual %b expected %b", rx_irq, mq.size() != 0);
        end
    endtask

    task automatic cyc(input bit v, input bit w, input int a, input logic [31:0] d);
        bus_valid = v; bus_write = w; bus_addr = 5'(a); bus_wdata = d;
        @(posedge clk);
        #1 model(v, w, a, d);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int a, input logic [31:0] d); cyc(1'b1, 1'b1, a, d); endtask
    task automatic rd(input int a); cyc(1'b1, 1'b0, a, 32'h0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        m_ovf = 1'b0; exp_rd = 32'h0;
        for (int i = 0; i < 16; i++) begin stg[i] = '0; wrm[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; compare(); cyc(1'b0, 1'b0, 0, 0); rd(0);
        // empty window reads
        cur_req = "R8"; rd(20); rd(31); rd(0);
        // full message, read back in order
        cur_req = "R3";
        for (int i = 16; i < 31; i++) wr(i, 32'hA000_0000 + 32'(i));
        cur_req = "R2"; wr(31, 32'hA000_00FF); rd(0);
        cur_req = "R3"; for (int i = 16; i < 31; i++) rd(i);
        cur_req = "R5"; rd(31); rd(0);
        // partial message after a full one
        cur_req = "R4";
        for (int i = 16; i < 31; i++) wr(i, 32'hB000_0000 + 32'(i));
        wr(31, 32'h1); wr(17, 32'hC17); wr(29, 32'hC29); wr(31, 32'hC31);
        rd(0); rd(31);
        for (int i = 16; i < 32; i++) rd(i);
        // ordering across several messages
        cur_req = "R3";
        for (int k = 0; k < 3; k++) begin
            wr(16, 32'h100 * 32'(k)); wr(20, 32'h5 + 32'(k)); wr(31, 32'hE0 + 32'(k));
        end
        for (int k = 0; k < 3; k++) begin rd(16); rd(20); rd(18); rd(31); end
        // ignored accesses
        cur_req = "R10";
        wr(31, 32'h77); wr(0, 32'hFFFF_FFFF); wr(5, 32'h1234); wr(15, 32'h9);
        rd(3); rd(15); rd(0); rd(16); rd(31); rd(1);
        cur_req = "R6"; rd(0);
        // fill past capacity
        cur_req = "R9";
        for (int k = 0; k < 129; k++) wr(31, 32'(k));
        rd(0); rd(16); rd(30);
        cur_req = "R6"; rd(0);
        cur_req = "R9";
        for (int k = 0; k < 128; k++) rd(31);
        cur_req = "R8"; rd(31); rd(16); rd(0);
        cur_req = "R9"; rd(0);
        cur_req = "R7"; cyc(1'b0, 1'b0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule